// File: doc/BRIEF.md
# Parallel Odd-Even Transposition Sorter

This block sorts a batch of unsigned words that are held in a bank of registers. A serial chain loads the words one per cycle, so no wide write decoder is needed. Once the batch is complete, a start request sets off a fixed number of compare-exchange phases. All adjacent pairs of one pairing are handled in the same cycle, and each phase alternates between the pairing that begins at slot 0 and the pairing that begins at slot 1. After as many phases as there are words, the bank holds the words in ascending order.

The result leaves through the same kind of chain, smallest word first, one per cycle, together with a valid flag. No N-to-1 read multiplexer is needed. A done flag marks the first output word. The default build sorts 48 words of 8 bits. The word count and the width are parameters.

Top module: `parsort_top`

## Requirements
- R1: While reset is high and in the first cycle after reset, `done_o` and `dout_valid_o` are 0 and `dout_o` is 0.
- R2: A cycle with `load_i` high (and no accepted start) shifts `din_i` into the top slot, and every slot moves down by one. After N loads the first word loaded sits in slot 0.
- R3: A start request is accepted only when exactly N words have been loaded since reset or since the last unload. With fewer or more loads it is ignored and no output appears. After more than N loads, only a reset re-arms the block.
- R4: Sorting takes exactly N clock edges after the edge that accepts start. The first phase uses pairs (0,1),(2,3),... and the phases then alternate. `done_o` is high for exactly one cycle, the cycle after the N-th phase edge.
- R5: `dout_valid_o` is high for exactly N consecutive cycles starting in the cycle that `done_o` is high, and is low in the cycle before and the cycle after.
- R6: The output words come out in ascending unsigned order, smallest first. The output stream is a permutation of the loaded batch, with duplicates kept. Equal neighbours are never exchanged.
- R7: Load strobes and start requests that arrive during sorting or unloading have no effect on the output stream. After an unload, the load count is zero.
- R8: After the last output word, the block accepts a new batch of N loads and a start, and sorts it correctly.
- R9: Any input order is sorted within N phases, including a strictly descending batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Shift `din_i` into the register chain |
| din_i | input | W | Word to load |
| start_i | input | 1 | Request to sort the loaded batch |
| done_o | output | 1 | One-cycle flag with the first sorted word |
| dout_o | output | W | Serial sorted output (slot 0) |
| dout_valid_o | output | 1 | `dout_o` carries a sorted word |

## Verification
On every cycle the assertions check four things: the output stream never decreases while valid stays high, done lasts a single cycle and comes with valid, done follows directly from the sorting state, and a start with the wrong load count leaves the block in its load state. Only the bench scenarios can show the rest. These are the exact phase count and the position of done, the full contents of each sorted batch including duplicates and the reverse-ordered worst case, and the fact that strobes during a sort do not disturb the result. They also show that short or long loads are rejected and that the block re-arms after an unload.

// File: rtl/parsort_pkg.sv
package parsort_pkg;

    localparam int PARSORT_DEF_N = 48;
    localparam int PARSORT_DEF_W = 8;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_SORT   = 2'd1,
        ST_UNLOAD = 2'd2
    } parsort_state_e;

    // Per-cycle command from the controller to the register bank.
    typedef struct packed {
        logic shift_in;   // load a word at the top of the chain
        logic shift_out;  // unload: move every slot down by one
        logic exch;       // run one compare-exchange phase
        logic odd;        // phase pairs start at slot 1 when set
    } parsort_cmd_t;

endpackage

// File: rtl/parsort_cx.sv
module parsort_cx #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);
    // Strictly greater only: equal words stay where they are.
    logic swap;
    assign swap = (a_i > b_i);
    assign lo_o = swap ? b_i : a_i;
    assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/parsort_ctrl.sv
module parsort_ctrl
    import parsort_pkg::*;
#(
    parameter int N = PARSORT_DEF_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         start_i,
    output parsort_cmd_t cmd_o,
    output logic         done_o,
    output logic         valid_o
);
    localparam int CW = $clog2(N + 2);
    localparam int PW = $clog2(N);
    localparam logic [CW-1:0] CNT_FULL = CW'(N);
    localparam logic [CW-1:0] CNT_OVER = CW'(N + 1);
    localparam logic [PW-1:0] LAST_IX  = PW'(N - 1);

    parsort_state_e state_q;
    logic [CW-1:0]  cnt_q;
    logic [PW-1:0]  phase_q;
    logic [PW-1:0]  ucnt_q;
    logic           start_ok;

    assign start_ok = (state_q == ST_LOAD) && start_i && (cnt_q == CNT_FULL);

    always_comb begin
        cmd_o.shift_in  = (state_q == ST_LOAD) && load_i && !start_ok;
        cmd_o.shift_out = (state_q == ST_UNLOAD);
        cmd_o.exch      = (state_q == ST_SORT);
        cmd_o.odd       = phase_q[0];
    end

    assign valid_o = (state_q == ST_UNLOAD);
    assign done_o  = (state_q == ST_UNLOAD) && (ucnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
            phase_q <= '0;
            ucnt_q  <= '0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (start_ok) begin
                        state_q <= ST_SORT;
                        phase_q <= '0;
                        cnt_q   <= '0;
                    end else if (load_i && cnt_q != CNT_OVER) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SORT: begin
                    phase_q <= phase_q + 1'b1;
                    if (phase_q == LAST_IX) begin
                        state_q <= ST_UNLOAD;
                        ucnt_q  <= '0;
                    end
                end
                ST_UNLOAD: begin
                    ucnt_q <= ucnt_q + 1'b1;
                    if (ucnt_q == LAST_IX) begin
                        state_q <= ST_LOAD;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_LOAD;
            endcase
        end
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && start_i && cnt_q != CNT_FULL) |=> (state_q == ST_LOAD)); // R3

    AST_DONE_AFTER_SORT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(state_q) == ST_SORT)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4

endmodule

// File: rtl/parsort_top.sv
module parsort_top
    import parsort_pkg::*;
#(
    parameter int N = PARSORT_DEF_N,
    parameter int W = PARSORT_DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         start_i,
    output logic         done_o,
    output logic [W-1:0] dout_o,
    output logic         dout_valid_o
);
    parsort_cmd_t cmd;
    logic [W-1:0] slot_q   [N];
    logic [W-1:0] nxt_even [N];
    logic [W-1:0] nxt_odd  [N];
    logic [W-1:0] lo_w     [N-1];
    logic [W-1:0] hi_w     [N-1];
    logic [W-1:0] fill;

    parsort_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (start_i),
        .cmd_o   (cmd),
        .done_o  (done_o),
        .valid_o (dout_valid_o)
    );

    // One comparator per adjacent pair; a phase uses every other one.
    for (genvar i = 0; i < N - 1; i++) begin : g_cx
        parsort_cx #(.W(W)) u_cx (
            .a_i  (slot_q[i]),
            .b_i  (slot_q[i+1]),
            .lo_o (lo_w[i]),
            .hi_o (hi_w[i])
        );
    end

    // Per-slot next value for each phase parity.
    for (genvar k = 0; k < N; k++) begin : g_slot
        if (k % 2 == 0) begin : g_ev
            if (k + 1 < N) begin : g_e
                assign nxt_even[k] = lo_w[k];
            end else begin : g_e
                assign nxt_even[k] = slot_q[k];
            end
            if (k >= 1) begin : g_o
                assign nxt_odd[k] = hi_w[k-1];
            end else begin : g_o
                assign nxt_odd[k] = slot_q[k];
            end
        end else begin : g_od
            assign nxt_even[k] = hi_w[k-1];
            if (k + 1 < N) begin : g_o
                assign nxt_odd[k] = lo_w[k];
            end else begin : g_o
                assign nxt_odd[k] = slot_q[k];
            end
        end
    end

    assign fill = cmd.shift_in ? din_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) slot_q[k] <= '0;
        end else if (cmd.shift_in || cmd.shift_out) begin
            for (int k = 0; k < N - 1; k++) slot_q[k] <= slot_q[k+1];
            slot_q[N-1] <= fill;
        end else if (cmd.exch) begin
            for (int k = 0; k < N; k++)
                slot_q[k] <= cmd.odd ? nxt_odd[k] : nxt_even[k];
        end
    end

    assign dout_o = slot_q[0];

    AST_ORDERED_OUT: assert property (@(posedge clk) disable iff (rst)
        (dout_valid_o && $past(dout_valid_o)) |-> (dout_o >= $past(dout_o))); // R6

    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        done_o |-> dout_valid_o); // R5

endmodule

// File: tb/parsort_top_tb.sv
module parsort_top_tb;
    localparam int N = 8;
    localparam int W = 8;
    localparam int NB = 4;

    // Stimulus batches (N words each) and their sorted results.
    localparam logic [W-1:0] STIM [0:NB*N-1] = '{
        8'd5, 8'd3, 8'd8, 8'd1, 8'd9, 8'd2, 8'd7, 8'd4,
        8'd255, 8'd254, 8'd253, 8'd252, 8'd251, 8'd250, 8'd249, 8'd248,
        8'd7, 8'd7, 8'd0, 8'd255, 8'd7, 8'd0, 8'd128, 8'd127,
        8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80
    };
    localparam logic [W-1:0] EXPV [0:NB*N-1] = '{
        8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd7, 8'd8, 8'd9,
        8'd248, 8'd249, 8'd250, 8'd251, 8'd252, 8'd253, 8'd254, 8'd255,
        8'd0, 8'd0, 8'd7, 8'd7, 8'd7, 8'd127, 8'd128, 8'd255,
        8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_i = 1'b0;
    logic [W-1:0] din_i = '0;
    logic start_i = 1'b0;
    logic done_o;
    logic [W-1:0] dout_o;
    logic dout_valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    parsort_top #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst(rst), .load_i(load_i), .din_i(din_i),
        .start_i(start_i), .done_o(done_o), .dout_o(dout_o),
        .dout_valid_o(dout_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_words(input int b, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            load_i = 1'b1;
            din_i  = STIM[b*N + i];
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        load_i  = 1'b0;
        start_i = 1'b1;
    endtask

    // Start accepted expected; noise=1 drives loads and starts mid-sort (R7).
    task automatic start_check(input int b, input bit noise, input string req);
        pulse_start();
        for (int c = 1; c <= N; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (noise && c >= 2 && c <= 4) begin
                load_i = 1'b1; din_i = '0; start_i = 1'b1;
            end else begin
                load_i = 1'b0;
            end
            if (c == N) chk(!dout_valid_o && !done_o, "R5 no valid before done", int'(dout_valid_o), 0);
        end
        @(negedge clk);
        if (noise) begin load_i = 1'b1; start_i = 1'b1; din_i = '0; end
        chk(done_o == 1'b1, "R4 done after N phases", int'(done_o), 1);
        chk(dout_valid_o == 1'b1, "R5 valid with done", int'(dout_valid_o), 1);
        chk(dout_o == EXPV[b*N], req, int'(dout_o), int'(EXPV[b*N]));
        for (int j = 1; j < N; j++) begin
            @(negedge clk);
            chk(dout_valid_o && !done_o, "R5 valid run / R4 single done", int'(dout_valid_o), 1);
            chk(dout_o == EXPV[b*N + j], req, int'(dout_o), int'(EXPV[b*N + j]));
        end
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        chk(!dout_valid_o, "R5 valid ends after N", int'(dout_valid_o), 0);
    endtask

    task automatic expect_no_output(input string req);
        bit seen = 1'b0;
        pulse_start();
        for (int c = 0; c < N + 4; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (dout_valid_o || done_o) seen = 1'b1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load_i = 1'b0; start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(!done_o && !dout_valid_o, "R1 flags in reset", int'(dout_valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !dout_valid_o && dout_o == '0, "R1 after reset", int'(dout_o), 0);
    endtask

    initial begin
        do_reset();
        // Table walk: R2 load order, R6 ascending with duplicates, R9 reverse batch.
        for (int b = 0; b < NB; b++) begin
            load_words(b, N);
            start_check(b, 1'b0, (b == 1) ? "R9 reverse batch" : "R6 sorted word");
        end
        // R3: too few loads, start ignored; completing the batch then works (R2).
        load_words(0, N - 1);
        expect_no_output("R3 start with N-1 loads");
        @(negedge clk); load_i = 1'b1; din_i = STIM[N - 1];
        start_check(0, 1'b0, "R2 load completed after ignored start");
        // R7: strobes during sort/unload ignored; count cleared afterwards.
        load_words(2, N);
        start_check(2, 1'b1, "R7 strobes mid-sort ignored");
        expect_no_output("R7 start after unload without loads");
        // R8: new batch after unload.
        load_words(1, N);
        start_check(1, 1'b0, "R8 next batch");
        // R3: too many loads, start ignored until reset.
        load_words(3, N);
        @(negedge clk); load_i = 1'b1; din_i = 8'd99;
        expect_no_output("R3 start with N+1 loads");
        do_reset();
        load_words(3, N);
        start_check(3, 1'b0, "R8 batch after re-arm");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule